// File: doc/BRIEF.md
# Stopwatch Timer with Two BCD Digits

This block is a small stopwatch peripheral for a microcontroller-style register bus. It keeps two cascaded 4-bit BCD digits, hundredths of a second and tenths of a second. A 100 Hz tick-enable input, one clock wide, advances the count. Software starts and stops the count with a run bit and zeroes it with a self-clearing clear bit. It reads both digits back over the same register port.

Each time the hundredths digit rolls over, a 10 Hz event occurs. Each time the tenths digit rolls over, a 1 Hz event occurs. Each event sets its own sticky factor flag whether or not its interrupt is enabled. The interrupt output is raised while any flag is set and its enable bit is 1. A read of the flag register returns the flags and then clears them, but a flag whose event lands in the same cycle as the read stays set.

Read data is combinational from the address. The read strobe only marks the access, so that the read-to-clear side effect takes place.

Top module: `swt_unit`

## Requirements
- R1: After a synchronous active-low reset, both digits are 0, the run bit is 0, both enables are 0, both flags are 0 and `irq` is 0.
- R2: Address 0 returns the hundredths digit and address 1 returns the tenths digit, each as BCD in bits 3:0. Writes to these addresses change nothing.
- R3: Address 2 bit 0 is the run bit, which can be read and written. While it is 0, ticks leave both digits unchanged.
- R4: A tick while running advances the hundredths digit by one through 0 to 9. On the step from 9 to 0, the tenths digit advances by one, also wrapping from 9 to 0. The digits always hold values 0 to 9.
- R5: Writing address 2 with bit 1 set zeroes both digits at that clock edge, and a tick in the same cycle is dropped. Bit 1 of address 2 always reads 0.
- R6: Address 4 bit 0 is the 10 Hz flag, set when the hundredths digit wraps. Address 4 bit 1 is the 1 Hz flag, set when the tenths digit wraps. Both flags are set regardless of the enables.
- R7: A read strobe at address 4 returns the flags and clears them at that clock edge. A flag whose setting event occurs in the same cycle remains 1.
- R8: Address 3 bit 0 enables the 10 Hz flag and bit 1 enables the 1 Hz flag. `irq` is 1 exactly when some flag is 1 with its enable bit 1.
- R9: Addresses 5 to 7 read as 0, and register bits with no function read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_100hz | input | 1 | One-cycle count enable at 100 Hz |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 4 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (clears flags when at address 4) |
| reg_rdata | output | 4 | Read data for the addressed register |
| irq | output | 1 | Interrupt request, level |

## Verification
The assertions take the tick, the strobes and the address to be known values that change only between clock edges. They also assume a write and a read are never both aimed at the flag register in one cycle. The bench drives every input on the falling edge and raises one strobe per access. The exception is the deliberate same-cycle cases: a tick together with a clear write, and a tick together with a flag read. Ticks are single pulses separated by register accesses, as a real 100 Hz enable would be. The sweeps run the counter through more than two full 0 to 99 cycles, so every carry and both flag events are reached.

// File: rtl/swt_pkg.sv
// Package: shared constants and the register-select type of the stopwatch.
// Assumes digits are 4-bit BCD and the register port is at least 4 bits wide.
package swt_pkg;
    localparam int BCD_LAST = 9;
    localparam int RUN_BIT  = 0;
    localparam int CLR_BIT  = 1;

    typedef enum logic [2:0] {
        SEL_DIGIT = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_FLAG  = 3'd3,
        SEL_NONE  = 3'd4
    } swt_sel_e;
endpackage

// File: rtl/swt_bcd_digit.sv
// Module: one BCD decade counter stage with synchronous clear.
// Assumes inc is a one-cycle enable. wrap reports the 9-to-0 step, which
// feeds the next stage. clr has priority over inc.
module swt_bcd_digit #(
    parameter int DIGIT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    output logic [DIGIT_W-1:0] val,
    output logic               wrap
);
    import swt_pkg::*;

    localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(BCD_LAST);

    // Carry out: asserted while this stage steps from its last value.
    assign wrap = inc && (val == LAST);

    // Digit register: clear, wrap to zero, or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (clr) begin
            val <= '0;
        end else if (inc) begin
            val <= wrap ? '0 : val + DIGIT_W'(1);
        end
    end
endmodule

// File: rtl/swt_flags.sv
// Module: sticky interrupt factor flags with read-to-clear.
// Assumes set_ev pulses for one cycle per event. A set in the same cycle as
// a read-clear wins, so no event is lost.
module swt_flags #(
    parameter int N_FLAGS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] set_ev,
    input  logic               rd_clr,
    output logic [N_FLAGS-1:0] flags_q
);
    logic [N_FLAGS-1:0] kept;

    // Bits that survive this cycle's read-clear.
    assign kept = rd_clr ? '0 : flags_q;

    // Flag register: keep or clear, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= kept | set_ev;
        end
    end
endmodule

// File: rtl/swt_regs.sv
// Module: register decode, control and enable storage, and the read mux.
// Map: digits at 0..N_DIGITS-1, control at N_DIGITS, enables at N_DIGITS+1,
// flags at N_DIGITS+2. Assumes N_DIGITS <= DATA_W and DIGIT_W <= DATA_W.
module swt_regs #(
    parameter int N_DIGITS = 2,
    parameter int DIGIT_W  = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    input  logic                         reg_we,
    input  logic                         reg_re,
    input  logic [N_DIGITS*DIGIT_W-1:0]  digits,
    input  logic [N_DIGITS-1:0]          flags,
    output logic                         run_q,
    output logic                         clr_req,
    output logic [N_DIGITS-1:0]          mask_q,
    output logic                         flags_rd,
    output logic [DATA_W-1:0]            reg_rdata
);
    import swt_pkg::*;

    localparam int CTRL_A = N_DIGITS;
    localparam int MASK_A = N_DIGITS + 1;
    localparam int FLAG_A = N_DIGITS + 2;

    swt_sel_e sel;

    // Address decode into a register select.
    always_comb begin
        if (reg_addr < ADDR_W'(N_DIGITS))           sel = SEL_DIGIT;
        else if (reg_addr == ADDR_W'(CTRL_A))       sel = SEL_CTRL;
        else if (reg_addr == ADDR_W'(MASK_A))       sel = SEL_MASK;
        else if (reg_addr == ADDR_W'(FLAG_A))       sel = SEL_FLAG;
        else                                        sel = SEL_NONE;
    end

    // Strobes that leave this block: clear request and flag read.
    assign clr_req  = reg_we && (sel == SEL_CTRL) && reg_wdata[CLR_BIT];
    assign flags_rd = reg_re && (sel == SEL_FLAG);

    // Run bit storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
        end else if (reg_we && (sel == SEL_CTRL)) begin
            run_q <= reg_wdata[RUN_BIT];
        end
    end

    // Interrupt enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (reg_we && (sel == SEL_MASK)) begin
            mask_q <= reg_wdata[N_DIGITS-1:0];
        end
    end

    // Read mux: the addressed register, zero-extended.
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_DIGIT: begin
                for (int i = 0; i < N_DIGITS; i++) begin
                    if (reg_addr == ADDR_W'(i)) begin
                        reg_rdata[DIGIT_W-1:0] = digits[i*DIGIT_W +: DIGIT_W];
                    end
                end
            end
            SEL_CTRL: reg_rdata[RUN_BIT]        = run_q;
            SEL_MASK: reg_rdata[N_DIGITS-1:0]   = mask_q;
            SEL_FLAG: reg_rdata[N_DIGITS-1:0]   = flags;
            default:  reg_rdata                 = '0;
        endcase
    end
endmodule

// File: rtl/swt_unit.sv
// Module: stopwatch top. A chain of BCD stages counts gated 100 Hz ticks.
// Each stage's wrap sets one sticky flag, and irq is the enabled OR of the
// flags. Assumes tick_100hz is a one-cycle enable.
module swt_unit #(
    parameter int N_DIGITS = 2,
    parameter int DIGIT_W  = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    logic                        run_q;
    logic                        clr_req;
    logic                        flags_rd;
    logic [N_DIGITS-1:0]         mask_q;
    logic [N_DIGITS-1:0]         flags_q;
    logic [N_DIGITS*DIGIT_W-1:0] digit_vals;
    logic [N_DIGITS:0]           carry;

    // Count enable of the first stage; a clear drops the tick.
    assign carry[0] = tick_100hz && run_q && !clr_req;

    // Cascade of decade stages, each enabled by the previous wrap.
    for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
        swt_bcd_digit #(.DIGIT_W(DIGIT_W)) digit_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_req),
            .inc   (carry[g]),
            .val   (digit_vals[g*DIGIT_W +: DIGIT_W]),
            .wrap  (carry[g+1])
        );
    end

    swt_flags #(.N_FLAGS(N_DIGITS)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (carry[N_DIGITS:1]),
        .rd_clr  (flags_rd),
        .flags_q (flags_q)
    );

    swt_regs #(
        .N_DIGITS (N_DIGITS),
        .DIGIT_W  (DIGIT_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .digits    (digit_vals),
        .flags     (flags_q),
        .run_q     (run_q),
        .clr_req   (clr_req),
        .mask_q    (mask_q),
        .flags_rd  (flags_rd),
        .reg_rdata (reg_rdata)
    );

    // Interrupt request: any flag whose enable is set.
    assign irq = |(flags_q & mask_q);
endmodule

// File: rtl/swt_unit_chk.sv
// Module: property checker for swt_unit, attached by bind. It observes the
// first two digits, the control state, the flags and the register port.
module swt_unit_chk #(
    parameter int N_DIGITS = 2,
    parameter int DIGIT_W  = 4,
    parameter int ADDR_W   = 3,
    parameter int DATA_W   = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        tick,
    input logic                        run,
    input logic                        clr,
    input logic [N_DIGITS*DIGIT_W-1:0] digits,
    input logic [N_DIGITS-1:0]         flags,
    input logic [N_DIGITS-1:0]         mask,
    input logic [ADDR_W-1:0]           addr,
    input logic                        re,
    input logic [DATA_W-1:0]           rdata,
    input logic                        irq
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(N_DIGITS);
    localparam logic [ADDR_W-1:0] FLAG_A = ADDR_W'(N_DIGITS + 2);

    logic [DIGIT_W-1:0] d0, d1;
    logic               step, wrap0;
    assign d0    = digits[DIGIT_W-1:0];
    assign d1    = digits[2*DIGIT_W-1:DIGIT_W];
    assign step  = tick && run && !clr;
    assign wrap0 = step && (d0 == DIGIT_W'(9));

    assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (d0 <= DIGIT_W'(9)) && (d1 <= DIGIT_W'(9)));

    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && run) && !clr) |=> $stable(digits));

    assert_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && d0 != DIGIT_W'(9)) |=> (d0 == $past(d0) + DIGIT_W'(1)) && $stable(d1));

    assert_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap0 |=> (d0 == '0) &&
                  (d1 == (($past(d1) == DIGIT_W'(9)) ? '0 : $past(d1) + DIGIT_W'(1))));

    assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (d0 == '0) && (d1 == '0));

    assert_clear_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == CTRL_A) |-> !rdata[1]);

    assert_flag10_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap0 |=> flags[0]);

    assert_flag_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (re && addr == FLAG_A && !wrap0) |=> !flags[0]);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask == '0) || (flags == '0)) |-> !irq);

    assert_unused_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > FLAG_A) |-> (rdata == '0));
endmodule

bind swt_unit swt_unit_chk #(
    .N_DIGITS (N_DIGITS),
    .DIGIT_W  (DIGIT_W),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W)
) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_100hz),
    .run    (run_q),
    .clr    (clr_req),
    .digits (digit_vals),
    .flags  (flags_q),
    .mask   (mask_q),
    .addr   (reg_addr),
    .re     (reg_re),
    .rdata  (reg_rdata),
    .irq    (irq)
);

// File: tb/swt_unit_tb_top.sv
module swt_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [3:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [3:0] reg_rdata;
    logic       irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    swt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_re(reg_re), .reg_rdata(reg_rdata), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<200000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_wdata = 4'(d); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 3'(a); reg_re = 1'b1;
        #1 d = int'(reg_rdata);
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_100hz = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0;
    endtask

    initial begin
        int v, cnt, f10, f1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(a, v);
            chk("R1 reset register value", v, 0);
        end
        chk("R1 reset irq", int'(irq), 0);

        // R9 unused addresses read 0
        for (int a = 5; a < 8; a++) begin
            rd(a, v);
            chk("R9 unused address", v, 0);
        end

        // R3 run bit readback; R5 clear bit reads 0
        wr(2, 4'b0011);
        rd(2, v);
        chk("R3/R5 control readback", v, 1);
        rd(4, v);

        // R4/R6/R7 sweep: 205 ticks, digits and flags from an arithmetic model
        cnt = 0; f10 = 0; f1 = 0;
        for (int k = 1; k <= 205; k++) begin
            if (cnt % 10 == 9) f10 = 1;
            if (cnt == 99) f1 = 1;
            cnt = (cnt + 1) % 100;
            tick();
            rd(0, v);
            chk("R4 hundredths digit", v, cnt % 10);
            rd(1, v);
            chk("R4 tenths digit", v, cnt / 10);
            if (k % 7 == 0) begin
                rd(4, v);
                chk("R6/R7 flags read", v, f1 * 2 + f10);
                f10 = 0; f1 = 0;
            end
        end
        rd(4, v);
        rd(4, v);
        chk("R7 flags cleared by read", v, 0);

        // R3 stopped: ticks ignored
        wr(2, 0);
        for (int k = 0; k < 5; k++) tick();
        rd(0, v);
        chk("R3 hundredths held while stopped", v, cnt % 10);
        rd(1, v);
        chk("R3 tenths held while stopped", v, cnt / 10);
        rd(2, v);
        chk("R3 run bit reads 0", v, 0);

        // R2 writes to digit addresses ignored
        wr(0, 7); wr(1, 3);
        rd(0, v);
        chk("R2 hundredths unaffected by write", v, cnt % 10);
        rd(1, v);
        chk("R2 tenths unaffected by write", v, cnt / 10);

        // R5 clear in the same cycle as a tick (hundredths is 5, not 9)
        wr(2, 1);
        @(negedge clk);
        reg_addr = 3'd2; reg_wdata = 4'b0011; reg_we = 1'b1; tick_100hz = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; tick_100hz = 1'b0;
        rd(0, v);
        chk("R5 hundredths cleared over tick", v, 0);
        rd(1, v);
        chk("R5 tenths cleared over tick", v, 0);
        rd(4, v);
        chk("R5 no flag from dropped tick", v, 0);

        // R7 flag set in the same cycle as its read stays set
        for (int k = 0; k < 9; k++) tick();
        @(negedge clk);
        reg_addr = 3'd4; reg_re = 1'b1; tick_100hz = 1'b1;
        #1 chk("R7 read before event", int'(reg_rdata), 0);
        @(negedge clk);
        reg_re = 1'b0; tick_100hz = 1'b0;
        rd(4, v);
        chk("R7 event beats read clear", v, 1);

        // R8 irq for every enable pattern with both flags set
        wr(3, 0);
        wr(2, 4'b0011);
        for (int k = 0; k < 100; k++) tick();
        for (int m = 0; m < 4; m++) begin
            wr(3, m);
            rd(3, v);
            chk("R8 enable readback", v, m);
            @(negedge clk);
            chk("R8 irq with both flags", int'(irq), (m != 0) ? 1 : 0);
        end

        // R8 only the 10 Hz flag set
        rd(4, v);
        for (int k = 0; k < 10; k++) tick();
        for (int m = 0; m < 4; m++) begin
            wr(3, m);
            @(negedge clk);
            chk("R8 irq with 10 Hz flag only", int'(irq), m % 2);
        end
        rd(4, v);
        @(negedge clk);
        chk("R8 irq drops after flag read", int'(irq), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule